// File: doc/BRIEF.md
# Two-Level Interrupt Flag and Enable Controller

This block gathers single-cycle event pulses from a set of peripheral sources and decides when to raise an interrupt request toward a processor core. Every source owns a sticky pending flag, an enable bit and a priority bit. One global master enable gates new interrupts from the idle state. When a request is raised, the block presents the number of the winning source as a vector index and its priority level, and holds both until the core acknowledges entry.

The core drives three strobes: an instruction-boundary strobe, an entry strobe when it begins a handler, and a return strobe when it executes a return-from-interrupt. Entry clears the master enable in hardware. On return the master enable comes back only on the next instruction boundary after the return, so a waiting request cannot be taken before the return jump has finished. A high-priority source may interrupt a low-priority handler. Flags of sources whose enable is clear are driven out as hardware trigger lines for other modules, such as a DMA engine, and every flag can be read for polling.

Software reaches the flags, enables, priorities and master enable through a write port. A 2-bit select picks the target and the data carries one bit per source.

Top module: `irq_flag_ctrl`

## Requirements
- R1: An event pulse on a source input sets that source's pending flag on the next clock edge, whether or not its enable is set. The flag then stays set until software clears it.
- R2: A write with select code 0 clears each flag whose data bit is 1 and leaves flags with a 0 data bit untouched. If an event for the same source arrives in the same cycle as its clear, the event wins and the flag stays set.
- R3: Select code 1 writes the enable bits. A source can raise a request only when both its flag and its enable bit are set.
- R4: The trigger output equals the flags whose enable bit is clear, in every cycle.
- R5: Select code 3 writes the master enable from data bit 0. After reset the master enable is 0, and no request is raised from the idle state while it is 0.
- R6: An entry strobe while the request is asserted drops the request and clears the master enable on the next clock edge.
- R7: A return strobe restores the master enable on the first instruction-boundary strobe strictly after it. An instruction-boundary strobe in the same cycle as the return does not count. The restored value is 1 when returning to the main program and 0 when returning from a high-level handler into a low-level one. No request can rise on that same boundary.
- R8: Select code 2 writes the priority bits, where 1 means high. While a low-level handler runs, only high-level requests can be raised. While a high-level handler runs, no request is raised.
- R9: Among eligible sources, high level beats low level and the lowest-numbered source wins within a level. The vector output is the source number in binary, and the level output is 1 for high.
- R10: Once raised, the request stays asserted with unchanged vector and level until the entry strobe, even if other sources become eligible.
- R11: The request is registered. It rises only in the cycle after an instruction-boundary strobe that coincided with an eligible source.
- R12: An entry strobe while no request is asserted has no effect on the master enable or the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt_i | input | N_SRC | Per-source event pulses |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 flag clear, 1 enable, 2 priority, 3 master |
| wr_data_i | input | N_SRC | Write data, one bit per source |
| insn_done_i | input | 1 | Instruction-boundary strobe from the core |
| irq_ack_i | input | 1 | Interrupt entry strobe |
| irq_ret_i | input | 1 | Return-from-interrupt strobe |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | IDX_W | Winning source number |
| irq_lvl_o | output | 1 | Winning level, 1 = high |
| flags_o | output | N_SRC | Raw pending flags for polling |
| trig_o | output | N_SRC | Flags of disabled sources, for hardware triggering |
| master_en_o | output | 1 | Current master enable |

## Verification
A corrupted flag shows at flags_o one cycle after the faulty edge, and at trig_o in the same cycle. A wrong enable or priority bit only shows once a request rises or fails to rise after the next instruction boundary. An error in the handler-nesting state stays hidden until a later strobe. It shows as a request that rises when it must not, or as a wrong master value after a return. For that reason the bench walks complete entry-and-return sequences at both levels rather than single strobes.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // write-port targets
    typedef enum logic [1:0] {
        WR_FLAG_CLR = 2'd0,
        WR_ENABLE   = 2'd1,
        WR_PRIO     = 2'd2,
        WR_MASTER   = 2'd3
    } wr_sel_e;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_e;

    // which handler levels are currently running
    typedef struct packed {
        logic low_act;
        logic high_act;
    } nest_t;

    // master value to restore when the innermost handler returns
    function automatic logic restore_master(nest_t n);
        return !(n.high_act && n.low_act);
    endfunction

    // nesting state after the innermost handler returns
    function automatic nest_t pop_level(nest_t n);
        nest_t r;
        r = n;
        if (n.high_act) r.high_act = 1'b0;
        else            r.low_act  = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank
    import irqc_pkg::*;
#(
    parameter int unsigned N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] evt_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [N_SRC-1:0] wr_data_i,
    output logic [N_SRC-1:0] flags_o,
    output logic [N_SRC-1:0] enables_o,
    output logic [N_SRC-1:0] prio_o
);

    logic [N_SRC-1:0] flag_q, flag_nxt;
    logic [N_SRC-1:0] en_q, prio_q;
    logic             clr_sel;

    assign clr_sel = wr_en_i && (wr_sel_e'(wr_sel_i) == WR_FLAG_CLR);

    // per-source sticky flag: event has priority over a same-cycle clear
    for (genvar g = 0; g < N_SRC; g++) begin : g_flag
        assign flag_nxt[g] = evt_i[g] | (flag_q[g] & ~(clr_sel & wr_data_i[g]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
            en_q   <= '0;
            prio_q <= '0;
        end else begin
            flag_q <= flag_nxt;
            if (wr_en_i && (wr_sel_e'(wr_sel_i) == WR_ENABLE)) en_q   <= wr_data_i;
            if (wr_en_i && (wr_sel_e'(wr_sel_i) == WR_PRIO))   prio_q <= wr_data_i;
        end
    end

    assign flags_o   = flag_q;
    assign enables_o = en_q;
    assign prio_o    = prio_q;

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
#(
    parameter int unsigned N_SRC = 8,
    localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] hi_req_i,
    input  logic [N_SRC-1:0] lo_req_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o,
    output lvl_e             lvl_o
);

    logic [IDX_W-1:0] hi_idx, lo_idx;
    logic             hi_hit, lo_hit;

    // lowest-numbered set bit wins: scan downward, last match sticks
    always_comb begin
        hi_idx = '0;
        hi_hit = 1'b0;
        lo_idx = '0;
        lo_hit = 1'b0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (hi_req_i[i]) begin
                hi_idx = IDX_W'(i);
                hi_hit = 1'b1;
            end
            if (lo_req_i[i]) begin
                lo_idx = IDX_W'(i);
                lo_hit = 1'b1;
            end
        end
    end

    always_comb begin
        hit_o = hi_hit | lo_hit;
        if (hi_hit) begin
            idx_o = hi_idx;
            lvl_o = LVL_HIGH;
        end else begin
            idx_o = lo_idx;
            lvl_o = LVL_LOW;
        end
    end

endmodule

// File: rtl/irqc_master_ctl.sv
module irqc_master_ctl
    import irqc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  take_i,
    input  lvl_e  take_lvl_i,
    input  logic  ret_i,
    input  logic  done_i,
    input  logic  mwr_i,
    input  logic  mdata_i,
    output logic  gie_o,
    output nest_t nest_o
);

    logic  gie_q;
    logic  arm_q;
    logic  restore_q;
    nest_t nest_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gie_q     <= 1'b0;
            arm_q     <= 1'b0;
            restore_q <= 1'b0;
            nest_q    <= '0;
        end else if (take_i) begin
            // entry: block further interrupts, record the running level
            gie_q <= 1'b0;
            arm_q <= 1'b0;
            if (take_lvl_i == LVL_HIGH) nest_q.high_act <= 1'b1;
            else                        nest_q.low_act  <= 1'b1;
        end else if (mwr_i) begin
            gie_q <= mdata_i;
            arm_q <= 1'b0;
        end else if (ret_i) begin
            // return: arm the restore, applied on a later boundary
            arm_q     <= 1'b1;
            restore_q <= restore_master(nest_q);
            nest_q    <= pop_level(nest_q);
        end else if (arm_q && done_i) begin
            gie_q <= restore_q;
            arm_q <= 1'b0;
        end
    end

    assign gie_o  = gie_q;
    assign nest_o = nest_q;

endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned N_SRC = 8,
    localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] src_evt_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [N_SRC-1:0] wr_data_i,
    input  logic             insn_done_i,
    input  logic             irq_ack_i,
    input  logic             irq_ret_i,
    output logic             irq_req_o,
    output logic [IDX_W-1:0] irq_vec_o,
    output logic             irq_lvl_o,
    output logic [N_SRC-1:0] flags_o,
    output logic [N_SRC-1:0] trig_o,
    output logic             master_en_o
);

    logic [N_SRC-1:0] flags, enables, prio;
    logic [N_SRC-1:0] elig, hi_mask, lo_mask;
    logic             gie;
    nest_t            nest;
    logic             low_act_w, high_act_w;
    logic             high_ok, low_ok;
    logic             win_hit;
    logic [IDX_W-1:0] win_idx;
    lvl_e             win_lvl;
    logic             req_q;
    logic [IDX_W-1:0] vec_q;
    lvl_e             lvl_q;
    logic             take;

    irqc_flag_bank #(.N_SRC(N_SRC)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (src_evt_i),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .flags_o   (flags),
        .enables_o (enables),
        .prio_o    (prio)
    );

    assign take = irq_ack_i && req_q;

    irqc_master_ctl u_master (
        .clk        (clk),
        .rst        (rst),
        .take_i     (take),
        .take_lvl_i (lvl_q),
        .ret_i      (irq_ret_i),
        .done_i     (insn_done_i),
        .mwr_i      (wr_en_i && (wr_sel_e'(wr_sel_i) == WR_MASTER)),
        .mdata_i    (wr_data_i[0]),
        .gie_o      (gie),
        .nest_o     (nest)
    );

    assign low_act_w  = nest.low_act;
    assign high_act_w = nest.high_act;

    // level gating: idle needs the master; a low handler admits only high
    assign low_ok  = gie && !low_act_w && !high_act_w;
    assign high_ok = low_ok || (low_act_w && !high_act_w);

    assign elig    = flags & enables;
    assign hi_mask = elig &  prio & {N_SRC{high_ok}};
    assign lo_mask = elig & ~prio & {N_SRC{low_ok}};

    irqc_arbiter #(.N_SRC(N_SRC)) u_arb (
        .hi_req_i (hi_mask),
        .lo_req_i (lo_mask),
        .hit_o    (win_hit),
        .idx_o    (win_idx),
        .lvl_o    (win_lvl)
    );

    // registered request, latched at an instruction boundary, held until entry
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            vec_q <= '0;
            lvl_q <= LVL_LOW;
        end else if (take) begin
            req_q <= 1'b0;
        end else if (!req_q && insn_done_i && win_hit) begin
            req_q <= 1'b1;
            vec_q <= win_idx;
            lvl_q <= win_lvl;
        end
    end

    assign irq_req_o   = req_q;
    assign irq_vec_o   = vec_q;
    assign irq_lvl_o   = lvl_q;
    assign flags_o     = flags;
    assign trig_o      = flags & ~enables;
    assign master_en_o = gie;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int unsigned N_SRC = 8,
    localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic [N_SRC-1:0] src_evt_i,
    input logic             wr_en_i,
    input logic [1:0]       wr_sel_i,
    input logic [N_SRC-1:0] wr_data_i,
    input logic             insn_done_i,
    input logic             irq_ack_i,
    input logic             irq_ret_i,
    input logic             irq_req_o,
    input logic [IDX_W-1:0] irq_vec_o,
    input logic             irq_lvl_o,
    input logic [N_SRC-1:0] flags_o,
    input logic [N_SRC-1:0] trig_o,
    input logic             master_en_o,
    input logic             low_act,
    input logic             high_act
);

    p_evt_sets_flag_r1: assert property (@(posedge clk) disable iff (rst)
        (|src_evt_i) |=> ((flags_o & $past(src_evt_i)) == $past(src_evt_i)));

    p_clear_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_sel_i == 2'd0)
        |=> ((flags_o & $past(wr_data_i & ~src_evt_i)) == '0));

    p_flag_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (!(|src_evt_i) && !(wr_en_i && wr_sel_i == 2'd0)) |=> $stable(flags_o));

    p_req_enabled_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req_o)
        |-> (|($past(flags_o & ~trig_o) & (N_SRC'(1) << irq_vec_o))));

    p_low_needs_master_r5: assert property (@(posedge clk) disable iff (rst)
        ($rose(irq_req_o) && !irq_lvl_o) |-> $past(master_en_o));

    p_entry_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (irq_ack_i && irq_req_o && !irq_ret_i) |=> (!master_en_o && !irq_req_o));

    p_no_early_rearm_r7: assert property (@(posedge clk) disable iff (rst)
        (irq_ret_i && !irq_ack_i && !wr_en_i && !master_en_o) |=> !master_en_o);

    p_rearm_on_boundary_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(master_en_o) |-> ($past(insn_done_i) || $past(wr_en_i && wr_sel_i == 2'd3)));

    p_low_only_idle_r8: assert property (@(posedge clk) disable iff (rst)
        ($rose(irq_req_o) && !irq_lvl_o) |-> $past(!low_act && !high_act));

    p_none_in_high_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req_o) |-> !$past(high_act));

    p_hold_until_entry_r10: assert property (@(posedge clk) disable iff (rst)
        (irq_req_o && !irq_ack_i)
        |=> (irq_req_o && $stable(irq_vec_o) && $stable(irq_lvl_o)));

    p_req_at_boundary_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req_o) |-> $past(insn_done_i));

    p_stray_entry_r12: assert property (@(posedge clk) disable iff (rst)
        (irq_ack_i && !irq_req_o && !irq_ret_i && !wr_en_i && !insn_done_i)
        |=> ($stable(master_en_o) && !irq_req_o));

endmodule

bind irq_flag_ctrl irqc_checker #(.N_SRC(N_SRC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .src_evt_i   (src_evt_i),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .wr_data_i   (wr_data_i),
    .insn_done_i (insn_done_i),
    .irq_ack_i   (irq_ack_i),
    .irq_ret_i   (irq_ret_i),
    .irq_req_o   (irq_req_o),
    .irq_vec_o   (irq_vec_o),
    .irq_lvl_o   (irq_lvl_o),
    .flags_o     (flags_o),
    .trig_o      (trig_o),
    .master_en_o (master_en_o),
    .low_act     (low_act_w),
    .high_act    (high_act_w)
);

// File: tb/irq_flag_ctrl_tb_top.sv
module irq_flag_ctrl_tb_top;

    localparam int N = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  src_evt = '0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = '0;
    logic [N-1:0]  wr_data = '0;
    logic          insn_done = 1'b0;
    logic          irq_ack = 1'b0;
    logic          irq_ret = 1'b0;
    logic          irq_req;
    logic [IW-1:0] irq_vec;
    logic          irq_lvl;
    logic [N-1:0]  flags;
    logic [N-1:0]  trig;
    logic          master_en;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    irq_flag_ctrl #(.N_SRC(N)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .src_evt_i   (src_evt),
        .wr_en_i     (wr_en),
        .wr_sel_i    (wr_sel),
        .wr_data_i   (wr_data),
        .insn_done_i (insn_done),
        .irq_ack_i   (irq_ack),
        .irq_ret_i   (irq_ret),
        .irq_req_o   (irq_req),
        .irq_vec_o   (irq_vec),
        .irq_lvl_o   (irq_lvl),
        .flags_o     (flags),
        .trig_o      (trig),
        .master_en_o (master_en)
    );

    // arbitration table: {events, enables, priorities, exp_hit, exp_vec, exp_lvl}
    localparam int NV = 8;
    localparam logic [28:0] ARB_TAB [NV] = '{
        {8'h04, 8'hFF, 8'h00, 1'b1, 3'd2, 1'b0},
        {8'hA0, 8'hFF, 8'h00, 1'b1, 3'd5, 1'b0},
        {8'h06, 8'hFB, 8'h00, 1'b1, 3'd1, 1'b0},
        {8'h83, 8'hFF, 8'h80, 1'b1, 3'd7, 1'b1},
        {8'h50, 8'hFF, 8'h50, 1'b1, 3'd4, 1'b1},
        {8'h10, 8'hEF, 8'h00, 1'b0, 3'd0, 1'b0},
        {8'h00, 8'hFF, 8'hFF, 1'b0, 3'd0, 1'b0},
        {8'h09, 8'hFF, 8'h08, 1'b1, 3'd3, 1'b1}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // drive one cycle of inputs from a falling edge, then return them to idle
    task automatic op(input logic [N-1:0] ev, input logic we, input logic [1:0] sel,
                      input logic [N-1:0] dat, input logic dn, input logic ak, input logic rt);
        src_evt = ev; wr_en = we; wr_sel = sel; wr_data = dat;
        insn_done = dn; irq_ack = ak; irq_ret = rt;
        @(negedge clk);
        src_evt = '0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        insn_done = 1'b0; irq_ack = 1'b0; irq_ret = 1'b0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [N-1:0] dat);
        op('0, 1'b1, sel, dat, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic idle();
        op('0, 1'b0, 2'd0, '0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // reset state (R5)
        check("R5 reset req", irq_req, 0);
        check("R5 reset master", master_en, 0);
        check("R5 reset flags", flags, 0);
        check("R4 reset trig", trig, 0);

        // table walk: priority and vector selection (R9, R3)
        for (int i = 0; i < NV; i++) begin
            do_reset();
            wr(2'd1, ARB_TAB[i][20:13]);
            wr(2'd2, ARB_TAB[i][12:5]);
            wr(2'd3, 8'h01);
            op(ARB_TAB[i][28:21], 1'b0, 2'd0, '0, 1'b0, 1'b0, 1'b0);
            op('0, 1'b0, 2'd0, '0, 1'b1, 1'b0, 1'b0);
            check("R9/R3 table req", irq_req, ARB_TAB[i][4]);
            if (ARB_TAB[i][4]) begin
                check("R9 table vec", irq_vec, ARB_TAB[i][3:1]);
                check("R9 table lvl", irq_lvl, ARB_TAB[i][0]);
            end
        end

        // R1/R4: flag set with enable clear, visible as trigger, no request (R3)
        do_reset();
        op(8'h01, 1'b0, 2'd0, '0, 1'b0, 1'b0, 1'b0);
        check("R1 flag on disabled source", flags, 8'h01);
        check("R4 trigger of disabled flag", trig, 8'h01);
        wr(2'd3, 8'h01);
        op('0, 1'b0, 2'd0, '0, 1'b1, 1'b0, 1'b0);
        check("R3 no req for disabled source", irq_req, 0);

        // R2: clear racing an event, clear of another bit, plain clear
        op(8'h01, 1'b1, 2'd0, 8'h01, 1'b0, 1'b0, 1'b0);
        check("R2 event beats clear", flags, 8'h01);
        wr(2'd0, 8'h02);
        check("R2 zero bits untouched", flags, 8'h01);
        wr(2'd0, 8'h01);
        check("R2 write-one clears", flags, 8'h00);

        // R5: master off blocks an enabled source
        do_reset();
        wr(2'd1, 8'h08);
        op(8'h08, 1'b0, 2'd0, '0, 1'b0, 1'b0, 1'b0);
        op('0, 1'b0, 2'd0, '0, 1'b1, 1'b0, 1'b0);
        check("R5 no req with master off", irq_req, 0);

        // R12: stray entry strobe
        wr(2'd3, 8'h01);
        op('0, 1'b0, 2'd0, '0, 1'b0, 1'b1, 1'b0);
        check("R12 stray entry master", master_en, 1);
        check("R12 stray entry req", irq_req, 0);

        // R11: nothing without a boundary strobe
        idle(); idle(); idle();
        check("R11 no req without boundary", irq_req, 0);
        op('0, 1'b0, 2'd0, '0, 1'b1, 1'b0, 1'b0);
        check("R11 req after boundary", irq_req, 1);
        check("R11 vec", irq_vec, 3);

        // R10: lower-numbered source appears while request is held
        wr(2'd1, 8'h09);
        op(8'h01, 1'b0, 2'd0, '0, 1'b0, 1'b0, 1'b0);
        op('0, 1'b0, 2'd0, '0, 1'b1, 1'b0, 1'b0);
        check("R10 req held", irq_req, 1);
        check("R10 vec held", irq_vec, 3);

        // R6: entry into low handler
        op('0, 1'b0, 2'd0, '0, 1'b0, 1'b1, 1'b0);
        check("R6 entry drops req", irq_req, 0);
        check("R6 entry clears master", master_en, 0);

        // R8: low sources cannot nest into low handler
        op('0, 1'b0, 2'd0, '0, 1'b1, 1'b0, 1'b0);
        check("R8 no low nest", irq_req, 0);

        // R8: high source preempts low handler
        wr(2'd2, 8'h01);
        op('0, 1'b0, 2'd0, '0, 1'b1, 1'b0, 1'b0);
        check("R8 high preempts req", irq_req, 1);
        check("R8 high preempts vec", irq_vec, 0);
        check("R8 high preempts lvl", irq_lvl, 1);
        op('0, 1'b0, 2'd0, '0, 1'b0, 1'b1, 1'b0);
        op('0, 1'b0, 2'd0, '0, 1'b1, 1'b0, 1'b0);
        check("R8 nothing in high handler", irq_req, 0);

        // R7: return from high into low keeps master off
        wr(2'd0, 8'h01);
        op('0, 1'b0, 2'd0, '0, 1'b1, 1'b0, 1'b1);
        check("R7 same-cycle boundary ignored", master_en, 0);
        op('0, 1'b0, 2'd0, '0, 1'b1, 1'b0, 1'b0);
        check("R7 restore off into low handler", master_en, 0);
        check("R7 no req back in low handler", irq_req, 0);

        // R7: return from low to main re-arms one boundary later
        op('0, 1'b0, 2'd0, '0, 1'b0, 1'b0, 1'b1);
        check("R7 master off right after return", master_en, 0);
        op('0, 1'b0, 2'd0, '0, 1'b1, 1'b0, 1'b0);
        check("R7 master back on", master_en, 1);
        check("R7 no req on re-arm boundary", irq_req, 0);
        op('0, 1'b0, 2'd0, '0, 1'b1, 1'b0, 1'b0);
        check("R7 pending taken after re-arm", irq_req, 1);
        check("R7 pending vec", irq_vec, 3);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule